// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block holds four 16-bit segment base registers: code, data, stack and extra. It turns a 16-bit offset into a 20-bit physical address. The segment base is shifted left by four bit positions and added to the zero-extended offset. Any carry out of bit 19 is dropped, so many segment/offset pairs alias to the same physical location.

The caller says which kind of register the offset came from, and the block picks the segment from that:

- a fetch offset uses the code segment;
- stack and frame pointer offsets use the stack segment;
- source index offsets use the data segment;
- destination index offsets use the extra segment.

A valid override input can replace that choice for every kind except a fetch. Segment registers are written through a synchronous load port.

Alongside the memory path, the block passes a 16-bit I/O port address straight through without segmentation. A narrow mode clears the upper byte of that address. The address outputs are purely combinational from the current register contents.

Top module: `segAddrGen`

## Requirements
- R1: `physAddr` equals (segment value × 16 + `offset`) modulo 2^20, so a sum that carries past bit 19 wraps around to the bottom of the space.
- R2: After reset the code segment register holds FFFF and the other three hold 0000. A fetch with offset 0000 right after reset therefore gives FFFF0.
- R3: When `offsetKind` = 00 (fetch), the code segment is used and `ovrValid`/`ovrSeg` have no effect.
- R4: When `offsetKind` = 01 (stack/frame pointer) and no override is given, the stack segment is used.
- R5: When `offsetKind` = 10 (source index) and no override is given, the data segment is used.
- R6: When `offsetKind` = 11 (destination index) and no override is given, the extra segment is used.
- R7: When `ovrValid` is high and `offsetKind` is not 00, the segment named by `ovrSeg` is used, with the code 00=extra, 01=code, 10=stack, 11=data.
- R8: With `segLoadEn` high, the register named by `segLoadSel` (same code as R7) takes `segLoadData` at the next rising clock edge. An address formed in the same cycle still uses the old value, and the other three registers keep their values.
- R9: With `ioPage0` low, `ioAddr` equals `ioPort` over all 16 bits.
- R10: With `ioPage0` high, `ioAddr` is `ioPort[7:0]` with bits 15:8 forced to zero.
- R11: `segUsed` reports the code (same code as R7) of the segment that formed `physAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| segLoadEn | input | 1 | Write strobe for a segment register |
| segLoadSel | input | 2 | Segment to write (00 extra, 01 code, 10 stack, 11 data) |
| segLoadData | input | 16 | New segment base value |
| offsetKind | input | 2 | Offset source: 00 fetch, 01 stack/frame, 10 source, 11 destination |
| offset | input | 16 | Offset to translate |
| ovrValid | input | 1 | Segment override present |
| ovrSeg | input | 2 | Override segment code |
| ioPort | input | 16 | I/O port address in |
| ioPage0 | input | 1 | Restrict I/O address to the low 256 ports |
| physAddr | output | 20 | Translated physical address |
| segUsed | output | 2 | Code of the segment used for `physAddr` |
| ioAddr | output | 16 | I/O port address out |

## Verification
The hardest case to reach from the ports is a load and a translation through the same segment in one cycle, where the address must still reflect the old base. The stimulus drives such cycles on purpose, and also back-to-back loads of the same register. The wrap past bit 19 needs a large base combined with a large offset. The stimulus loads FFFF into a segment and applies offset FFFF. It also builds two different base/offset pairs that must alias to the same address. Beyond these directed cases, a long random stretch mixes loads, overrides and offset kinds, and every cycle is compared against a behavioural model.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } segSel_e;

  typedef enum logic [1:0] {
    OFS_FETCH = 2'b00,
    OFS_STACK = 2'b01,
    OFS_SRC   = 2'b10,
    OFS_DST   = 2'b11
  } ofsKind_e;

  localparam int NUM_SEG = 4;

  typedef struct packed {
    logic [1:0]         readSel;
    logic [NUM_SEG-1:0] writeHot;
    logic               ioNarrow;
  } segStrobe_t;
endpackage

// File: rtl/segAddrCtrl.sv
module segAddrCtrl
  import segaddr_pkg::*;
(
  input  logic       segLoadEn,
  input  logic [1:0] segLoadSel,
  input  logic [1:0] offsetKind,
  input  logic       ovrValid,
  input  logic [1:0] ovrSeg,
  input  logic       ioPage0,
  output segStrobe_t strobe
);
  segSel_e defaultSeg;

  // default segment from the offset's source register
  always_comb begin
    case (ofsKind_e'(offsetKind))
      OFS_FETCH: defaultSeg = SEG_CODE;
      OFS_STACK: defaultSeg = SEG_STACK;
      OFS_SRC:   defaultSeg = SEG_DATA;
      default:   defaultSeg = SEG_EXTRA;
    endcase
  end

  always_comb begin
    strobe.ioNarrow = ioPage0;
    if (ovrValid && (ofsKind_e'(offsetKind) != OFS_FETCH))
      strobe.readSel = ovrSeg;
    else
      strobe.readSel = defaultSeg;
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_wr
    assign strobe.writeHot[i] = segLoadEn && (segLoadSel == 2'(i));
  end
endmodule

// File: rtl/segAddrDatapath.sv
module segAddrDatapath
  import segaddr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter int IO_W = 16,
  parameter int IO_PAGE_W = 8,
  parameter logic [SEG_W-1:0] CODE_RESET = '1,
  localparam int PHYS_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic [SEG_W-1:0]  segLoadData,
  input  logic [OFS_W-1:0]  offset,
  input  logic [IO_W-1:0]   ioPort,
  output logic [PHYS_W-1:0] physAddr,
  output logic [IO_W-1:0]   ioAddr
);
  logic [SEG_W-1:0] segRegs [NUM_SEG];
  logic [SEG_W-1:0] segVal;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL =
      (i == int'(SEG_CODE)) ? CODE_RESET : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  segRegs[i] <= RST_VAL;
      else if (strobe.writeHot[i]) segRegs[i] <= segLoadData;
    end
  end

  assign segVal = segRegs[strobe.readSel];

  // shift-by-SHIFT add, truncated to PHYS_W bits (wraps)
  assign physAddr = {segVal, {SHIFT{1'b0}}}
                  + {{(PHYS_W-OFS_W){1'b0}}, offset};

  assign ioAddr = strobe.ioNarrow
                ? {{(IO_W-IO_PAGE_W){1'b0}}, ioPort[IO_PAGE_W-1:0]}
                : ioPort;
endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segaddr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter int IO_W = 16,
  parameter int IO_PAGE_W = 8,
  localparam int PHYS_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segLoadEn,
  input  logic [1:0]        segLoadSel,
  input  logic [SEG_W-1:0]  segLoadData,
  input  logic [1:0]        offsetKind,
  input  logic [OFS_W-1:0]  offset,
  input  logic              ovrValid,
  input  logic [1:0]        ovrSeg,
  input  logic [IO_W-1:0]   ioPort,
  input  logic              ioPage0,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        segUsed,
  output logic [IO_W-1:0]   ioAddr
);
  segStrobe_t strobe;

  segAddrCtrl u_ctrl (
    .segLoadEn (segLoadEn),
    .segLoadSel(segLoadSel),
    .offsetKind(offsetKind),
    .ovrValid  (ovrValid),
    .ovrSeg    (ovrSeg),
    .ioPage0   (ioPage0),
    .strobe    (strobe)
  );

  segAddrDatapath #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT),
    .IO_W(IO_W), .IO_PAGE_W(IO_PAGE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .segLoadData(segLoadData),
    .offset     (offset),
    .ioPort     (ioPort),
    .physAddr   (physAddr),
    .ioAddr     (ioAddr)
  );

  assign segUsed = strobe.readSel;
endmodule

// File: rtl/segAddrGen_checker.sv
module segAddrGen_checker (
  input logic        clk,
  input logic        rstN,
  input logic        segLoadEn,
  input logic [1:0]  segLoadSel,
  input logic [15:0] segLoadData,
  input logic [1:0]  offsetKind,
  input logic [15:0] offset,
  input logic        ovrValid,
  input logic [1:0]  ovrSeg,
  input logic [15:0] ioPort,
  input logic        ioPage0,
  input logic [19:0] physAddr,
  input logic [1:0]  segUsed,
  input logic [15:0] ioAddr
);
  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rstN)
    offsetKind == 2'b00 |-> segUsed == 2'b01); // R3
  AST_STACK_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (offsetKind == 2'b01 && !ovrValid) |-> segUsed == 2'b10); // R4
  AST_SRC_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (offsetKind == 2'b10 && !ovrValid) |-> segUsed == 2'b11); // R5
  AST_DST_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (offsetKind == 2'b11 && !ovrValid) |-> segUsed == 2'b00); // R6
  AST_OVERRIDE_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (offsetKind != 2'b00 && ovrValid) |-> segUsed == ovrSeg); // R7
  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    segLoadEn |=> (segUsed != $past(segLoadSel)) ||
      (physAddr == ({$past(segLoadData), 4'b0000} + {4'b0000, offset}))); // R8
  AST_IO_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    !ioPage0 |-> ioAddr == ioPort); // R9
  AST_IO_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    ioPage0 |-> (ioAddr[15:8] == 8'h00 && ioAddr[7:0] == ioPort[7:0])); // R10
  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[3:0] == offset[3:0]); // R1
endmodule

bind segAddrGen segAddrGen_checker u_chk (
  .clk(clk), .rstN(rstN), .segLoadEn(segLoadEn), .segLoadSel(segLoadSel),
  .segLoadData(segLoadData), .offsetKind(offsetKind), .offset(offset),
  .ovrValid(ovrValid), .ovrSeg(ovrSeg), .ioPort(ioPort), .ioPage0(ioPage0),
  .physAddr(physAddr), .segUsed(segUsed), .ioAddr(ioAddr)
);

// File: tb/segAddrGen_bench.sv
module segAddrGen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segLoadEn = 1'b0;
  logic [1:0]  segLoadSel = '0;
  logic [15:0] segLoadData = '0;
  logic [1:0]  offsetKind = '0;
  logic [15:0] offset = '0;
  logic        ovrValid = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic [15:0] ioPort = '0;
  logic        ioPage0 = 1'b0;
  logic [19:0] physAddr;
  logic [1:0]  segUsed;
  logic [15:0] ioAddr;

  int vectors = 0;
  int miscompares = 0;
  int mSeg [4];  // model: index 0 extra, 1 code, 2 stack, 3 data

  always #2 clk = ~clk;  // 250 MHz

  segAddrGen u_segAddrGen (.*);

  task automatic fail(string req, int act, int exp);
    miscompares++;
    $display("FAIL %s: actual %0h expected %0h", req, act, exp);
  endtask

  // one cycle: drive at negedge, compare mid-cycle, update model at posedge
  task automatic vec(input int kind, input int ofs, input bit ovV, input int ovS,
                     input bit ld, input int ldS, input int ldD,
                     input int io, input bit pg, input string tag);
    int segIdx, expAddr, expIo;
    @(negedge clk);
    offsetKind = 2'(kind); offset = 16'(ofs); ovrValid = ovV; ovrSeg = 2'(ovS);
    segLoadEn = ld; segLoadSel = 2'(ldS); segLoadData = 16'(ldD);
    ioPort = 16'(io); ioPage0 = pg;
    #1;
    if (kind == 0) segIdx = 1;          // R3
    else if (ovV) segIdx = ovS;         // R7
    else if (kind == 1) segIdx = 2;     // R4
    else if (kind == 2) segIdx = 3;     // R5
    else segIdx = 0;                    // R6
    expAddr = ((mSeg[segIdx] * 16) + ofs) % (1 << 20);  // R1
    expIo = pg ? (io & 'hFF) : (io & 'hFFFF);           // R9 R10
    vectors++;
    if (int'(physAddr) != expAddr) fail({tag, "/R1"}, int'(physAddr), expAddr);
    if (int'(segUsed) != segIdx) fail({tag, "/R11"}, int'(segUsed), segIdx);
    if (int'(ioAddr) != expIo) fail(pg ? "R10" : "R9", int'(ioAddr), expIo);
    @(posedge clk);
    if (ld) mSeg[ldS] = ldD & 'hFFFF;   // R8
  endtask

  initial begin
    #(4 * 100000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    mSeg[0] = 0; mSeg[1] = 'hFFFF; mSeg[2] = 0; mSeg[3] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R2 reset state
    vec(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    vec(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    vec(2, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    vec(3, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R8 loads; same-cycle read sees old value
    vec(1, 'h10, 0, 0, 1, 2, 'h1234, 'hABCD, 0, "R8");
    vec(1, 'h10, 0, 0, 1, 3, 'h2000, 'h0, 0, "R8");
    vec(2, 'h55, 0, 0, 1, 0, 'h3000, 'h1FF, 1, "R8");
    vec(3, 'h77, 0, 0, 1, 1, 'h0100, 'hFFFF, 1, "R8");
    vec(3, 'h77, 0, 0, 1, 0, 'h3001, 'h0, 0, "R8");
    vec(3, 'h77, 0, 0, 0, 0, 0, 'h0, 0, "R6");
    vec(0, 'h8, 1, 2, 0, 0, 0, 'h0, 0, "R3");
    vec(1, 'h8, 1, 3, 0, 0, 0, 'h0, 0, "R7");
    vec(2, 'h8, 1, 0, 0, 0, 0, 'h0, 0, "R7");
    vec(3, 'h8, 1, 1, 0, 0, 0, 'h0, 0, "R7");
    vec(3, 'h8, 1, 2, 0, 0, 0, 'h0, 0, "R7");
    vec(2, 'h9, 0, 0, 0, 0, 0, 'h0, 0, "R5");
    vec(1, 'h9, 0, 0, 0, 0, 0, 'h0, 0, "R4");
    // R1 wrap and aliasing
    vec(0, 0, 0, 0, 1, 1, 'hFFFF, 0, 0, "R1");
    vec(0, 'hFFFF, 0, 0, 1, 2, 'h002A, 0, 0, "R1");
    vec(1, 'h0023, 0, 0, 1, 3, 'h002C, 0, 0, "R1");
    vec(2, 'h0003, 0, 0, 0, 0, 0, 0, 0, "R1");
    vec(1, 'hFFFF, 1, 0, 0, 0, 0, 0, 0, "R7");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      vec(int'($urandom_range(0, 3)), int'($urandom_range(0, 'hFFFF)),
          bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
          bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
          int'($urandom_range(0, 'hFFFF)), int'($urandom_range(0, 'hFFFF)),
          bit'($urandom_range(0, 1)), "RND");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule